// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recently used logical-to-physical page mappings for a demand-paged memory manager. A lookup presents a 32-bit logical address together with a 3-bit function code. Every entry is compared at once, and the result comes back in the same cycle: either a hit with the physical address, or a miss that tells the surrounding logic to start a walk of the translation tables in memory.

The page size is chosen at run time from eight powers of two, 256 bytes up to 32 KB. The chosen size sets the split between the offset bits, which are copied unchanged from the logical address, and the page-number bits, which are compared and replaced. The function code is stored with each entry, so the same logical page in user space and in supervisor space gives two separate translations. A fill port writes new mappings. Entries are freed by a flush, or by any change of the page size.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup presented with `req_valid` high reports `miss`.
- R2: When `req_valid` is low, `hit` and `miss` are both low. When it is high, exactly one of them is high, in the same cycle as the request.
- R3: A lookup hits when a valid entry holds the same logical page number and the same function code. `paddr` is then the stored physical page number above the offset, combined with the request's own offset bits, and it is valid in the same cycle.
- R4: An entry written with one function code does not hit for a lookup of the same address under a different function code.
- R5: With `page_sel` = p, the offset is the low 8+p address bits. Changing an offset bit keeps the hit and changes the same bit of `paddr`. Changing bit 8+p of the address gives a miss.
- R6: A fill presented while a clock edge passes is visible to lookups from the next cycle on. It goes into the lowest-numbered invalid entry when one exists.
- R7: When every entry is valid and the fill matches none of them, the fill replaces the entry named by a round-robin pointer. The pointer starts at 0, moves to the next entry only after such a replacement, and wraps from the last entry back to 0. It returns to 0 on a flush or a page-size change.
- R8: A fill whose logical page and function code match a valid entry overwrites that entry with the new physical page. No other entry changes, and the round-robin pointer does not move.
- R9: `flush` clears every entry at the next clock edge. A fill presented in the same cycle is dropped.
- R10: In a cycle where `page_sel` differs from its value in the previous cycle, no lookup hits, and every entry is cleared at the end of that cycle. A fill presented in that cycle is dropped.
- R11: At most one entry matches any lookup. If several did, the lowest-numbered one would supply the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_sel | input | 3 | Page size select, page = 256 << page_sel bytes |
| flush | input | 1 | Clear all entries |
| req_valid | input | 1 | Lookup request present |
| req_laddr | input | 32 | Logical address of the lookup |
| req_fc | input | 3 | Function code of the lookup |
| hit | output | 1 | Lookup found a mapping |
| miss | output | 1 | Lookup found no mapping; a table walk is needed |
| paddr | output | 32 | Translated physical address, valid with hit |
| fill_valid | input | 1 | Write a mapping this cycle |
| fill_laddr | input | 32 | Logical address of the new mapping (offset bits ignored) |
| fill_fc | input | 3 | Function code of the new mapping |
| fill_paddr | input | 32 | Physical address of the new mapping (offset bits ignored) |

## Verification
The bench builds the cache with 4 entries rather than 22. This brings the full-cache state, the round-robin wrap from the last entry back to 0, and the no-move rule for a duplicate fill within reach in a handful of fills. The same sequence runs for all eight page sizes, each entered through a page-size change, so the offset/page boundary is tested on both sides at every size. Expected physical addresses come from shift-and-mask arithmetic on page numbers the bench picks.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Where a fill is written
  typedef enum logic [1:0] {
    FILL_DUP  = 2'd0,  // overwrite matching entry
    FILL_FREE = 2'd1,  // lowest invalid entry
    FILL_RR   = 2'd2   // round-robin victim
  } fill_kind_e;
endpackage

// File: rtl/xlat_tag_store.sv
module xlat_tag_store #(
  parameter int N   = 22,
  parameter int TW  = 24,
  parameter int FCW = 3,
  parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_all,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [TW-1:0]        wr_ltag,
  input  logic [FCW-1:0]       wr_fc,
  input  logic [TW-1:0]        wr_ptag,
  output logic [N-1:0]         valid_o,
  output logic [N-1:0][TW-1:0] ltag_o,
  output logic [N-1:0][FCW-1:0] fc_o,
  output logic [N-1:0][TW-1:0] ptag_o
);
  logic [N-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Tag and data fields carry no reset
  generate
    for (genvar e = 0; e < N; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == IW'(e))) begin
          ltag_o[e] <= wr_ltag;
          fc_o[e]   <= wr_fc;
          ptag_o[e] <= wr_ptag;
        end
      end
    end
  endgenerate

  assign valid_o = valid_q;
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N   = 22,
  parameter int TW  = 24,
  parameter int FCW = 3,
  parameter int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]          valid,
  input  logic [N-1:0][TW-1:0]  ltag,
  input  logic [N-1:0][FCW-1:0] fc,
  input  logic [TW-1:0]         key_tag,
  input  logic [FCW-1:0]        key_fc,
  input  logic [TW-1:0]         tag_mask,
  output logic [N-1:0]          match_vec,
  output logic [N-1:0]          first_oh,
  output logic                  any,
  output logic [IW-1:0]         first_idx
);
  generate
    for (genvar e = 0; e < N; e++) begin : g_cmp
      assign match_vec[e] = valid[e] && (fc[e] == key_fc) &&
                            (((ltag[e] ^ key_tag) & tag_mask) == '0);
    end
  endgenerate

  // Lowest-numbered match has priority
  always_comb begin
    first_idx = '0;
    first_oh  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        first_idx = IW'(i);
        first_oh  = '0;
        first_oh[i] = 1'b1;
      end
    end
  end

  assign any = |match_vec;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int N  = 22,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_all,
  input  logic          fill_req,
  input  logic [N-1:0]  valid,
  input  logic          dup_any,
  input  logic [IW-1:0] dup_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] free_idx;
  logic          free_any;
  fill_kind_e    kind;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    if (dup_any)       kind = FILL_DUP;
    else if (free_any) kind = FILL_FREE;
    else               kind = FILL_RR;
  end

  always_comb begin
    case (kind)
      FILL_DUP:  wr_idx = dup_idx;
      FILL_FREE: wr_idx = free_idx;
      default:   wr_idx = rr_q;
    endcase
  end

  assign wr_en = fill_req && !clear_all;

  always_ff @(posedge clk) begin
    if (rst || clear_all) begin
      rr_q <= '0;
    end else if (wr_en && (kind == FILL_RR)) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES   = 22,
  parameter int AW        = 32,
  parameter int FCW       = 3,
  parameter int PSW       = 3,
  parameter int MIN_SHIFT = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PSW-1:0] page_sel,
  input  logic           flush,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_laddr,
  input  logic [FCW-1:0] req_fc,
  output logic           hit,
  output logic           miss,
  output logic [AW-1:0]  paddr,
  input  logic           fill_valid,
  input  logic [AW-1:0]  fill_laddr,
  input  logic [FCW-1:0] fill_fc,
  input  logic [AW-1:0]  fill_paddr
);
  localparam int TW = AW - MIN_SHIFT;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PSW-1:0] sel_q;
  logic           size_chg;
  logic           clear_all;
  logic [TW-1:0]  tag_mask;

  logic [ENTRIES-1:0]           valid_vec;
  logic [ENTRIES-1:0][TW-1:0]   ltag;
  logic [ENTRIES-1:0][FCW-1:0]  fcs;
  logic [ENTRIES-1:0][TW-1:0]   ptag;

  logic [ENTRIES-1:0] look_match, look_oh;
  logic               look_any;
  logic [IW-1:0]      look_idx;
  logic [ENTRIES-1:0] fill_match, fill_oh;
  logic               fill_any;
  logic [IW-1:0]      fill_idx;

  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [TW-1:0] sel_ptag;
  logic [TW-1:0] req_tag;

  // Previous page size; loaded during reset too
  always_ff @(posedge clk) begin
    sel_q <= page_sel;
  end

  assign size_chg  = (page_sel != sel_q);
  assign clear_all = flush || size_chg;
  assign tag_mask  = {TW{1'b1}} << page_sel;
  assign req_tag   = req_laddr[AW-1:MIN_SHIFT];

  xlat_tag_store #(.N(ENTRIES), .TW(TW), .FCW(FCW), .IW(IW)) store_i (
    .clk       (clk),
    .rst       (rst),
    .clear_all (clear_all),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_ltag   (fill_laddr[AW-1:MIN_SHIFT]),
    .wr_fc     (fill_fc),
    .wr_ptag   (fill_paddr[AW-1:MIN_SHIFT]),
    .valid_o   (valid_vec),
    .ltag_o    (ltag),
    .fc_o      (fcs),
    .ptag_o    (ptag)
  );

  xlat_match #(.N(ENTRIES), .TW(TW), .FCW(FCW), .IW(IW)) look_i (
    .valid     (valid_vec),
    .ltag      (ltag),
    .fc        (fcs),
    .key_tag   (req_tag),
    .key_fc    (req_fc),
    .tag_mask  (tag_mask),
    .match_vec (look_match),
    .first_oh  (look_oh),
    .any       (look_any),
    .first_idx (look_idx)
  );

  xlat_match #(.N(ENTRIES), .TW(TW), .FCW(FCW), .IW(IW)) dup_i (
    .valid     (valid_vec),
    .ltag      (ltag),
    .fc        (fcs),
    .key_tag   (fill_laddr[AW-1:MIN_SHIFT]),
    .key_fc    (fill_fc),
    .tag_mask  (tag_mask),
    .match_vec (fill_match),
    .first_oh  (fill_oh),
    .any       (fill_any),
    .first_idx (fill_idx)
  );

  xlat_victim #(.N(ENTRIES), .IW(IW)) victim_i (
    .clk       (clk),
    .rst       (rst),
    .clear_all (clear_all),
    .fill_req  (fill_valid),
    .valid     (valid_vec),
    .dup_any   (fill_any),
    .dup_idx   (fill_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx)
  );

  // AND-OR select of the winning entry's physical page
  always_comb begin
    sel_ptag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_oh[i]) sel_ptag = sel_ptag | ptag[i];
    end
  end

  assign hit   = req_valid && look_any && !size_chg;
  assign miss  = req_valid && !hit;
  assign paddr = {(sel_ptag & tag_mask) | (req_tag & ~tag_mask),
                  req_laddr[MIN_SHIFT-1:0]};

  logic unused_ok;
  assign unused_ok = ^{look_idx, fill_oh};
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES   = 22,
  parameter int AW        = 32,
  parameter int PSW       = 3,
  parameter int MIN_SHIFT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [PSW-1:0]     page_sel,
  input logic               flush,
  input logic               req_valid,
  input logic [AW-1:0]      req_laddr,
  input logic               hit,
  input logic               miss,
  input logic [AW-1:0]      paddr,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec
);
  logic [AW-1:0] off_mask;
  assign off_mask = ~({AW{1'b1}} << (MIN_SHIFT + int'(page_sel)));

  assert_empty_miss_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && valid_vec == '0) |-> miss);

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!hit && !miss));

  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> (((paddr ^ req_laddr) & off_mask) == '0));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  assert_size_nohit_R10: assert property (@(posedge clk) disable iff (rst)
    (page_sel != $past(page_sel)) |-> !hit);

  assert_size_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (page_sel != $past(page_sel)) |=> (valid_vec == '0));

  assert_unique_match_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .AW(AW), .PSW(PSW), .MIN_SHIFT(MIN_SHIFT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .page_sel  (page_sel),
  .flush     (flush),
  .req_valid (req_valid),
  .req_laddr (req_laddr),
  .hit       (hit),
  .miss      (miss),
  .paddr     (paddr),
  .valid_vec (valid_vec),
  .match_vec (look_match)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  page_sel = 3'd0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_laddr = '0;
  logic [2:0]  req_fc = '0;
  logic        hit, miss;
  logic [31:0] paddr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_laddr = '0;
  logic [2:0]  fill_fc = '0;
  logic [31:0] fill_paddr = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int sh;

  always #5 clk = ~clk;

  xlat_cache #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst(rst), .page_sel(page_sel), .flush(flush),
    .req_valid(req_valid), .req_laddr(req_laddr), .req_fc(req_fc),
    .hit(hit), .miss(miss), .paddr(paddr),
    .fill_valid(fill_valid), .fill_laddr(fill_laddr),
    .fill_fc(fill_fc), .fill_paddr(fill_paddr)
  );

  function automatic logic [31:0] lo_mask(int s);
    return ~(32'hFFFF_FFFF << s);
  endfunction
  function automatic logic [31:0] la_of(int k, int s);
    return 32'hC000_0000 | (32'(k) << s) | (32'h00A5_C3E7 & lo_mask(s));
  endfunction
  function automatic logic [31:0] pa_of(int k, int v, int s);
    return 32'h3000_0000 | (32'(k * v + 1) << s) | (32'h00A5_C3E7 & lo_mask(s));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Lookup sampled 2 ns after the driving falling edge
  task automatic look(string tag, logic [31:0] la, logic [2:0] fc,
                      bit eh, logic [31:0] epa);
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la; req_fc = fc;
    #2;
    chk(tag, {30'd0, hit, miss}, {30'd0, eh, !eh});
    if (eh) chk(tag, paddr, epa);
  endtask

  task automatic fill(logic [31:0] la, logic [2:0] fc, logic [31:0] pa);
    @(negedge clk);
    fill_valid = 1'b1; fill_laddr = la; fill_fc = fc; fill_paddr = pa;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    look("R1 reset miss", la_of(1, 8), 3'd5, 0, '0);
    @(negedge clk) req_valid = 1'b0;
    #2 chk("R2 idle outputs", {30'd0, hit, miss}, 32'd0);

    for (int p = 0; p < 8; p++) begin
      sh = 8 + p;
      // page-size change cycle (p>0) or flush (p==0)
      @(negedge clk);
      if (p == 0) flush = 1'b1; else page_sel = 3'(p);
      req_valid = 1'b1; req_laddr = la_of(9, sh); req_fc = 3'd5;
      fill_valid = 1'b1; fill_laddr = la_of(1, sh); fill_fc = 3'd5;
      fill_paddr = pa_of(1, 3, sh);
      #2 chk("R10 no hit in size-change cycle", {31'd0, hit}, 32'd0);
      @(negedge clk) begin flush = 1'b0; fill_valid = 1'b0; end
      look("R10 old entries cleared, fill dropped", la_of(9, sh), 3'd5, 0, '0);
      look("R10 R9 same-cycle fill dropped", la_of(1, sh), 3'd5, 0, '0);

      for (int k = 1; k <= 4; k++) fill(la_of(k, sh), 3'd5, pa_of(k, 3, sh));
      for (int k = 1; k <= 4; k++)
        look("R3 R6 hit after fill", la_of(k, sh), 3'd5, 1, pa_of(k, 3, sh));
      look("R4 other function code misses", la_of(2, sh), 3'd1, 0, '0);
      look("R5 page bit flip misses", la_of(4, sh) ^ (32'd1 << sh), 3'd5, 0, '0);
      look("R5 offset bit passes", la_of(4, sh) ^ (32'd1 << (sh - 1)), 3'd5, 1,
           pa_of(4, 3, sh) ^ (32'd1 << (sh - 1)));

      // duplicate fill overwrites, pointer stays at 0
      fill(la_of(2, sh), 3'd5, pa_of(2, 11, sh));
      fill(la_of(5, sh), 3'd5, pa_of(5, 3, sh));
      look("R8 R7 entry0 evicted", la_of(1, sh), 3'd5, 0, '0);
      look("R8 new physical page", la_of(2, sh), 3'd5, 1, pa_of(2, 11, sh));
      look("R8 others kept", la_of(3, sh), 3'd5, 1, pa_of(3, 3, sh));
      look("R8 others kept", la_of(4, sh), 3'd5, 1, pa_of(4, 3, sh));
      look("R7 replacement hit", la_of(5, sh), 3'd5, 1, pa_of(5, 3, sh));

      // round robin through entries 1,2,3 then wrap to 0
      for (int k = 6; k <= 9; k++) fill(la_of(k, sh), 3'd5, pa_of(k, 3, sh));
      for (int k = 2; k <= 5; k++)
        look("R7 evicted in order", la_of(k, sh), 3'd5, 0, '0);
      for (int k = 6; k <= 9; k++)
        look("R7 round-robin wrap", la_of(k, sh), 3'd5, 1, pa_of(k, 3, sh));

      // flush with concurrent fill
      @(negedge clk);
      flush = 1'b1; fill_valid = 1'b1; fill_laddr = la_of(10, sh);
      fill_fc = 3'd5; fill_paddr = pa_of(10, 3, sh);
      @(negedge clk) begin flush = 1'b0; fill_valid = 1'b0; end
      look("R9 flush clears", la_of(6, sh), 3'd5, 0, '0);
      look("R9 fill with flush dropped", la_of(10, sh), 3'd5, 0, '0);

      // same page in two function codes
      fill(la_of(3, sh), 3'd2, pa_of(3, 5, sh));
      fill(la_of(3, sh), 3'd6, pa_of(3, 13, sh));
      look("R4 supervisor copy", la_of(3, sh), 3'd6, 1, pa_of(3, 13, sh));
      look("R4 user copy", la_of(3, sh), 3'd2, 1, pa_of(3, 5, sh));
      @(negedge clk) req_valid = 1'b0;
      #2 chk("R2 idle outputs", {30'd0, hit, miss}, 32'd0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule